// File: doc/BRIEF.md
# USB Endpoint Stall and Toggle Controller

This block keeps the per-endpoint control state of a USB device controller and picks the handshake for every token that the packet decoder hands it. Each endpoint has one small control register. It holds a transfer type, a halt flag for the host-to-device (receive) direction, a halt flag for the device-to-host (transmit) direction, and a strobe for each direction that restarts the data toggle.

A decoded token arrives as a one-cycle strobe. It carries an endpoint number, a token kind and two readiness flags from the buffer layer. One clock later the block presents a handshake code and the data toggle that applies to that transfer. A halted control endpoint is released by hardware when a new SETUP arrives. A halted bulk, interrupt or isochronous endpoint stays halted until software releases it. Software reads and writes the endpoint registers through a plain register port; reads are combinational.

Top module: `usb_ep_ctrl`

## Requirements
- R1: After reset, endpoint 0 reads back 0x00, which is type control (type code 00). Every other endpoint reads back 0x02, which is type bulk (type code 10). All halt and toggle bits are 0, and hs_valid is low.
- R2: A token accepted on a clock edge (tok_valid high) produces hs_valid high for exactly the following cycle. No token means hs_valid is low in the following cycle.
- R3: On an endpoint whose type is not 00, any token kind aimed at a halted direction is answered with STALL, and the halt bit is left set. Token codes: OUT=0, IN=1, SETUP=2, PING=3. Handshake codes: ACK=0, NAK=1, STALL=2, NYET=3. IN uses the transmit direction; the other three kinds use the receive direction.
- R4: On an endpoint whose type is not 00, a halt bit changes only through a register write.
- R5: On a type-00 endpoint, IN, OUT and PING aimed at a halted direction are answered with STALL, and the halt bit stays set.
- R6: On a type-00 endpoint, a SETUP is always answered with ACK, and hs_toggle is 0 for that SETUP. In the same cycle it clears both halt bits and sets both toggles to 1.
- R7: When the addressed direction is not halted, the handshake depends on the token kind and the readiness flags:
  - IN gives ACK when buf_ready is high and NAK when it is low.
  - OUT gives NAK when buf_ready is low. When buf_ready is high it gives ACK if nxt_ready is high and NYET if nxt_ready is low.
  - PING, and SETUP on an endpoint whose type is not 00, give ACK when buf_ready is high and NAK when it is low.
- R8: An IN answered with ACK flips the transmit toggle. An OUT answered with ACK or NYET flips the receive toggle. hs_toggle reports the toggle value from before the flip.
- R9: Writing 1 to bit 4 of a register forces that endpoint's receive toggle to 0, and writing 1 to bit 5 forces its transmit toggle to 0. This takes priority over any hardware toggle update in the same cycle. Bits 5 and 4 always read back as 0.
- R10: Register layout: bits [1:0] are the type, bit 2 is the receive halt and bit 3 is the transmit halt (both halts are written together in one write). Bit 6 reads the receive toggle and bit 7 reads the transmit toggle. A token in the same cycle as a write is answered from the state before the write.
- R11: When a SETUP on a type-00 endpoint and a register write that sets that endpoint's halt bits land in the same cycle, the halt bits end up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | EP_W | Endpoint register selected for read and write |
| reg_wdata | input | 6 | Write data: type, halts, toggle-restart strobes |
| reg_rdata | output | 8 | Read data for reg_addr |
| tok_valid | input | 1 | Decoded token strobe |
| tok_ep | input | EP_W | Token endpoint number |
| tok_kind | input | 2 | Token kind code |
| buf_ready | input | 1 | Buffer for this transfer is ready |
| nxt_ready | input | 1 | Following OUT buffer is ready |
| hs_valid | output | 1 | Handshake valid |
| hs_code | output | 2 | Handshake code |
| hs_toggle | output | 1 | Data toggle for this transfer |

## Verification
A SETUP that releases a halted control endpoint can land in the same cycle as a software write to that endpoint's register. Likewise, an accepted data token can coincide with a toggle-restart strobe on the same endpoint. The bench drives each pair in the same clock. It then reads the register back and confirms two things: the hardware release beats the software halt set, and the restart beats the hardware toggle flip. A third collision puts a write that halts an endpoint in the same cycle as an OUT to that endpoint. The bench confirms that this token is still answered from the old state and that the next OUT is stalled.

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [EP_W-1:0] reg_addr,
  input  logic [5:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            tok_valid,
  input  logic [EP_W-1:0] tok_ep,
  input  logic [1:0]      tok_kind,
  input  logic            buf_ready,
  input  logic            nxt_ready,
  output logic            hs_valid,
  output logic [1:0]      hs_code,
  output logic            hs_toggle
);
  localparam logic [1:0] K_OUT = 2'd0, K_IN = 2'd1, K_SETUP = 2'd2;
  localparam logic [1:0] H_ACK = 2'd0, H_NAK = 2'd1, H_STALL = 2'd2, H_NYET = 2'd3;
  localparam logic [1:0] T_CTRL = 2'b00, T_BULK = 2'b10;

  logic [NUM_EP-1:0][1:0] ep_type;
  logic [NUM_EP-1:0]      stall_rx, stall_tx, tog_rx, tog_tx;

  logic       is_tx, cur_stall, cur_tog, setup_ctrl, accept;
  logic [1:0] code;

  assign is_tx      = (tok_kind == K_IN);
  assign setup_ctrl = (tok_kind == K_SETUP) && (ep_type[tok_ep] == T_CTRL);
  assign cur_stall  = is_tx ? stall_tx[tok_ep] : stall_rx[tok_ep];
  assign cur_tog    = is_tx ? tog_tx[tok_ep]   : tog_rx[tok_ep];

  always_comb begin
    accept = 1'b0;
    code   = H_NAK;
    if (setup_ctrl) begin
      code = H_ACK;
    end else if (cur_stall) begin
      code = H_STALL;
    end else begin
      case (tok_kind)
        K_IN: begin
          code   = buf_ready ? H_ACK : H_NAK;
          accept = buf_ready;
        end
        K_OUT: begin
          if (!buf_ready)     code = H_NAK;
          else if (nxt_ready) code = H_ACK;
          else                code = H_NYET;
          accept = buf_ready;
        end
        default: code = buf_ready ? H_ACK : H_NAK;
      endcase
    end
  end

  assign reg_rdata = {tog_tx[reg_addr], tog_rx[reg_addr], 2'b00,
                      stall_tx[reg_addr], stall_rx[reg_addr], ep_type[reg_addr]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_EP; i++) begin
        ep_type[i]  <= (i == 0) ? T_CTRL : T_BULK;
        stall_rx[i] <= 1'b0;
        stall_tx[i] <= 1'b0;
        tog_rx[i]   <= 1'b0;
        tog_tx[i]   <= 1'b0;
      end
      hs_valid  <= 1'b0;
      hs_code   <= H_ACK;
      hs_toggle <= 1'b0;
    end else begin
      hs_valid <= tok_valid;
      if (tok_valid) begin
        hs_code   <= code;
        hs_toggle <= setup_ctrl ? 1'b0 : cur_tog;
      end
      for (int i = 0; i < NUM_EP; i++) begin
        if (reg_we && reg_addr == EP_W'(i))
          ep_type[i] <= reg_wdata[1:0];

        if (tok_valid && tok_ep == EP_W'(i) && setup_ctrl) begin
          stall_rx[i] <= 1'b0;
          stall_tx[i] <= 1'b0;
        end else if (reg_we && reg_addr == EP_W'(i)) begin
          stall_rx[i] <= reg_wdata[2];
          stall_tx[i] <= reg_wdata[3];
        end

        if (reg_we && reg_addr == EP_W'(i) && reg_wdata[4])
          tog_rx[i] <= 1'b0;
        else if (tok_valid && tok_ep == EP_W'(i) && setup_ctrl)
          tog_rx[i] <= 1'b1;
        else if (tok_valid && tok_ep == EP_W'(i) && accept && !is_tx)
          tog_rx[i] <= ~tog_rx[i];

        if (reg_we && reg_addr == EP_W'(i) && reg_wdata[5])
          tog_tx[i] <= 1'b0;
        else if (tok_valid && tok_ep == EP_W'(i) && setup_ctrl)
          tog_tx[i] <= 1'b1;
        else if (tok_valid && tok_ep == EP_W'(i) && accept && is_tx)
          tog_tx[i] <= ~tog_tx[i];
      end
    end
  end
endmodule

// File: rtl/usb_ep_ctrl_chk.sv
module usb_ep_ctrl_chk #(
  parameter int NUM_EP = 4,
  parameter int EP_W   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_we,
  input logic [EP_W-1:0]        reg_addr,
  input logic [5:0]             reg_wdata,
  input logic                   tok_valid,
  input logic [EP_W-1:0]        tok_ep,
  input logic [1:0]             tok_kind,
  input logic                   hs_valid,
  input logic [1:0]             hs_code,
  input logic [NUM_EP-1:0][1:0] ep_type,
  input logic [NUM_EP-1:0]      stall_rx,
  input logic [NUM_EP-1:0]      stall_tx,
  input logic [NUM_EP-1:0]      tog_rx
);
  logic tok_ctrl, tok_halted;
  assign tok_ctrl   = (ep_type[tok_ep] == 2'b00);
  assign tok_halted = (tok_kind == 2'd1) ? stall_tx[tok_ep] : stall_rx[tok_ep];

  a_r2_hs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |=> hs_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !hs_valid);
  a_r6_setup_ack: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_kind == 2'd2 && tok_ctrl |=> hs_code == 2'd0);
  a_r3_stall_resp: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_ctrl && tok_halted |=> hs_code == 2'd2);
  a_r5_ctrl_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_ctrl && tok_kind != 2'd2 && tok_halted |=> hs_code == 2'd2);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    a_r4_hold_rx: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == EP_W'(i)) && ep_type[i] != 2'b00 && stall_rx[i] |=> stall_rx[i]);
    a_r4_hold_tx: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == EP_W'(i)) && ep_type[i] != 2'b00 && stall_tx[i] |=> stall_tx[i]);
    a_r6_setup_clear: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid && tok_ep == EP_W'(i) && tok_kind == 2'd2 && ep_type[i] == 2'b00
      |=> !stall_rx[i] && !stall_tx[i]);
    a_r9_tog_restart: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_addr == EP_W'(i) && reg_wdata[4] |=> !tog_rx[i]);
  end
endmodule

bind usb_ep_ctrl usb_ep_ctrl_chk #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tok_valid(tok_valid), .tok_ep(tok_ep),
  .tok_kind(tok_kind), .hs_valid(hs_valid), .hs_code(hs_code),
  .ep_type(ep_type), .stall_rx(stall_rx), .stall_tx(stall_tx), .tog_rx(tog_rx)
);

// File: tb/tb_usb_ep_ctrl.sv
module tb_usb_ep_ctrl;
  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [5:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       tok_valid = 0;
  logic [1:0] tok_ep = 0, tok_kind = 0;
  logic       buf_ready = 0, nxt_ready = 0;
  logic       hs_valid, hs_toggle;
  logic [1:0] hs_code;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_ep_ctrl dut (.*);

  int mtype[4];
  bit msrx[4], mstx[4], mtrx[4], mttx[4];
  bit ev; int ec; bit et; string etag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        mtype[i] = (i == 0) ? 0 : 2; msrx[i] = 0; mstx[i] = 0; mtrx[i] = 0; mttx[i] = 0;
      end
      ev = 0; ec = 0; et = 0; etag = "R1";
    end else begin
      int e; bit tx, sc, acc;
      e = tok_ep; tx = (tok_kind == 1); sc = 0; acc = 0;
      ev = tok_valid;
      if (tok_valid) begin
        if (tok_kind == 2 && mtype[e] == 0) begin
          ec = 0; et = 0; etag = "R6"; sc = 1;
        end else if (tx ? mstx[e] : msrx[e]) begin
          ec = 2; et = tx ? mttx[e] : mtrx[e]; etag = (mtype[e] == 0) ? "R5" : "R3";
        end else begin
          et = tx ? mttx[e] : mtrx[e]; etag = "R7";
          if (tok_kind == 0) begin
            ec = !buf_ready ? 1 : (nxt_ready ? 0 : 3); acc = buf_ready;
          end else begin
            ec = buf_ready ? 0 : 1; acc = buf_ready && tx;
          end
          if (acc) etag = "R8";
        end
        if (sc) begin mtrx[e] = 1; mttx[e] = 1; end
        else if (acc) begin
          if (tx) mttx[e] = !mttx[e]; else mtrx[e] = !mtrx[e];
        end
      end
      if (reg_we) begin
        mtype[reg_addr] = reg_wdata[1:0];
        msrx[reg_addr] = reg_wdata[2]; mstx[reg_addr] = reg_wdata[3];
        if (reg_wdata[4]) mtrx[reg_addr] = 0;
        if (reg_wdata[5]) mttx[reg_addr] = 0;
      end
      if (sc) begin msrx[e] = 0; mstx[e] = 0; end
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] mr;
    mr = {mttx[reg_addr], mtrx[reg_addr], 2'b00, mstx[reg_addr], msrx[reg_addr], 2'(mtype[reg_addr])};
    check("R2", hs_valid, ev);
    if (ev) begin
      check(etag, hs_code, ec);
      check(etag, hs_toggle, et);
    end
    check("R10", reg_rdata, mr);
  end

  task automatic cyc(bit we, int wa, int wd, bit tv, int ep, int kind, bit rdy, bit nxt);
    @(posedge clk); #2;
    reg_we = we; reg_wdata = 6'(wd);
    if (we) reg_addr = 2'(wa);
    tok_valid = tv; tok_ep = 2'(ep); tok_kind = 2'(kind); buf_ready = rdy; nxt_ready = nxt;
  endtask
  task automatic tok(int ep, int kind, bit rdy, bit nxt); cyc(0, 0, 0, 1, ep, kind, rdy, nxt); endtask
  task automatic wr(int ep, int d); cyc(1, ep, d, 0, 0, 0, 0, 0); endtask
  task automatic rd(int ep, int exp, string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    reg_addr = 2'(ep);
    @(negedge clk); #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #23 rst_n = 1;
    check("R1", hs_valid, 0);
    rd(0, 8'h00, "R1"); rd(1, 8'h02, "R1"); rd(2, 8'h02, "R1"); rd(3, 8'h02, "R1");
    tok(1, 0, 1, 1); tok(1, 0, 1, 0); tok(1, 0, 0, 0);
    tok(1, 1, 1, 0); tok(1, 1, 0, 0); tok(1, 3, 1, 0); tok(1, 3, 0, 0);
    tok(1, 2, 1, 0); tok(1, 2, 0, 0);
    rd(1, 8'h82, "R8");
    wr(1, 6'h06);
    tok(1, 0, 1, 1); tok(1, 3, 1, 0); tok(1, 2, 1, 0); tok(1, 1, 1, 0);
    rd(1, 8'h06, "R4");
    tok(1, 0, 1, 1);
    rd(1, 8'h06, "R3");
    wr(1, 6'h02); tok(1, 0, 1, 1);
    wr(2, 6'h0B); tok(2, 1, 1, 0); tok(2, 0, 1, 1);
    wr(0, 6'h0C); tok(0, 1, 1, 0); tok(0, 0, 1, 1); tok(0, 3, 1, 0);
    rd(0, 8'h0C, "R5");
    tok(0, 2, 0, 0);
    rd(0, 8'hC0, "R6");
    tok(0, 1, 1, 0);
    wr(0, 6'h30);
    rd(0, 8'h00, "R9");
    cyc(1, 3, 6'h22, 1, 3, 1, 1, 0);
    rd(3, 8'h02, "R9");
    cyc(1, 0, 6'h0C, 1, 0, 2, 0, 0);
    rd(0, 8'hC0, "R11");
    cyc(1, 1, 6'h06, 1, 1, 0, 1, 1);
    tok(1, 0, 1, 1);
    rd(1, 8'h06, "R10");
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule